// File: doc/BRIEF.md
# Pre/Post-Trigger Record Capture Controller

This block steers a stream of parallel samples into an external circular record buffer, framing each record around a reference trigger. A start trigger opens record 0. The controller first fills a programmable pre-trigger window. That window is a ring that keeps overwriting its oldest entry until a reference trigger edge is accepted. Then it writes a programmable number of post-trigger samples behind the window. Once a record is complete, the controller waits for an advance trigger edge before opening the next record in the next buffer slot. This repeats until the programmed number of records has been taken.

The buffer RAM is outside the block. The controller drives a write enable, an address and the data, one cycle after each sample it accepts. The address is formed as the slot number above the offset within the record. The block also reports:
- the ring position of the oldest pre-trigger sample, so that software can unroll the record;
- an end-of-record pulse;
- a level showing that an advance trigger will be accepted;
- a done level;
- a sticky overflow flag, computed against a count of records the reader has already fetched.

Samples enter on a valid/ready interface. `in_ready` is high only while a record is being filled (pre-trigger or post-trigger phase). A sample is consumed on any cycle where both `in_valid` and `in_ready` are high. A consumed sample is discarded rather than stored when the pause input is high. Holding `in_valid` low simply stalls the record. No sample is ever held inside the block.

Top module: `rec_capture_ctrl`

## Requirements
- R1: After reset `in_ready`, `wr_en`, `eor`, `rdy_adv`, `done` and `overflow` are all low and the controller waits for a start trigger.
- R2: A high `start_trig` while idle or done opens record 0 in slot 0 on the next cycle; `in_ready` is high exactly while a record is being filled.
- R3: With `cfg_pre` = P > 0, stored pre-trigger samples go to offsets 0,1,…,P-1,0,1,… of the current slot, each new one overwriting the oldest.
- R4: A reference edge is accepted only once P pre-trigger samples have been stored for the record; earlier edges are ignored. On acceptance `ref_pos` takes the offset of the oldest pre-trigger sample, which is the stored count modulo P.
- R5: The sample handed over in the cycle a reference edge is accepted is the first post-trigger sample; post-trigger sample j goes to offset P+j, for j from 0 to `cfg_post`-1.
- R6: Polarity bits `cfg_ref_fall` and `cfg_adv_fall` select the active edge of the reference and advance inputs: 0 means a rising edge, 1 means a falling edge.
- R7: `eor` pulses for one cycle together with the write of the last post-trigger sample. With `cfg_post` = 0 it pulses one cycle after the reference edge is accepted, and the sample of that cycle is not stored.
- R8: Between records `rdy_adv` is high; an active advance edge then opens the next record in slot (previous slot + 1) modulo NSLOT. Advance edges at any other time are ignored.
- R9: After `cfg_records` records (a 31-bit count, 0 treated as 1), `done` goes high and stays high until the next start trigger.
- R10: A sample consumed while `pause_trig` is high is not written and does not advance any pointer or count.
- R11: `overflow` is set when record n is opened with n ≥ `fetched_cnt` + NSLOT; it stays set until a start trigger clears it.
- R12: A sample consumed at a clock edge appears on `wr_en`/`wr_addr`/`wr_data` in the following cycle; `wr_addr` is the slot number above the OFS_W-bit offset.
- R13: With `cfg_pre` = 0 nothing is stored before the reference edge, and the first reference edge of the record is accepted with `ref_pos` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Sample valid |
| in_ready | output | 1 | Sample accepted (record being filled) |
| in_data | input | DATA_W | Sample value |
| start_trig | input | 1 | Start trigger, level seen while idle or done |
| ref_trig | input | 1 | Reference trigger level |
| adv_trig | input | 1 | Advance trigger level |
| pause_trig | input | 1 | Discard consumed samples while high |
| cfg_pre | input | OFS_W+1 | Pre-trigger sample count |
| cfg_post | input | OFS_W+1 | Post-trigger sample count |
| cfg_records | input | 31 | Number of records |
| cfg_ref_fall | input | 1 | Reference edge polarity (1 = falling) |
| cfg_adv_fall | input | 1 | Advance edge polarity (1 = falling) |
| fetched_cnt | input | 31 | Records already fetched by the reader |
| wr_en | output | 1 | Buffer write enable |
| wr_addr | output | SLOT_W+OFS_W | Buffer write address |
| wr_data | output | DATA_W | Buffer write data |
| ref_pos | output | OFS_W | Oldest pre-trigger offset of the last accepted reference |
| eor | output | 1 | End-of-record pulse |
| rdy_adv | output | 1 | Advance trigger will be accepted |
| done | output | 1 | All records taken |
| overflow | output | 1 | Sticky unfetched-record overwrite flag |

## Verification
Reference acceptance and sample arrival can fall in the same cycle. That sample must become post-trigger sample 0 and not a further overwrite of the pre-trigger ring. With a one-sample post window, that same cycle also ends the record. The bench provokes this in every record of a sweep over all pre/post sizes from 0 to 4, with an ignored early reference edge and, on alternate configurations, pauses. It judges the result by unrolling the slot contents from `ref_pos` and comparing them with the sample sequence it sent.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_POST,
    ST_WAIT,
    ST_DONE
  } rcc_state_e;
endpackage

// File: rtl/rcc_edge_det.sv
module rcc_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic fall_i,
  output logic edge_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  assign edge_o = fall_i ? (prev_q & ~lvl_i) : (~prev_q & lvl_i);
endmodule

// File: rtl/rcc_window.sv
// Pre-trigger ring and post-trigger fill for the record being captured.
module rcc_window #(
  parameter int OFS_W = 3,
  localparam int CNT_W = OFS_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             in_pre_i,
  input  logic             in_post_i,
  input  logic             take_i,
  input  logic             ref_edge_i,
  input  logic [CNT_W-1:0] cfg_pre,
  input  logic [CNT_W-1:0] cfg_post,
  output logic             ref_ok_o,
  output logic             store_o,
  output logic [OFS_W-1:0] ofs_o,
  output logic             rec_end_o,
  output logic [OFS_W-1:0] ring_ptr_o
);
  logic [CNT_W-1:0] ptr_q, fill_q, pcnt_q;
  logic [CNT_W-1:0] post_idx, pcnt_nxt;
  logic [OFS_W-1:0] post_off;
  logic pre_nz, post_nz, pre_full, store_pre, store_post, post_last;

  assign pre_nz   = (cfg_pre != '0);
  assign post_nz  = (cfg_post != '0);
  assign pre_full = (fill_q == cfg_pre);
  assign ref_ok_o = in_pre_i & ref_edge_i & pre_full;

  assign store_pre  = in_pre_i & take_i & ~ref_ok_o & pre_nz;
  assign store_post = take_i & ((in_pre_i & ref_ok_o & post_nz) | in_post_i);
  assign store_o    = store_pre | store_post;

  assign post_idx = in_post_i ? pcnt_q : '0;
  assign pcnt_nxt = post_idx + CNT_W'(1);
  assign post_off = cfg_pre[OFS_W-1:0] + post_idx[OFS_W-1:0];
  assign ofs_o    = store_post ? post_off : ptr_q[OFS_W-1:0];
  assign post_last = take_i & (pcnt_nxt == cfg_post);

  assign rec_end_o = (in_pre_i & ref_ok_o & (~post_nz | post_last)) |
                     (in_post_i & post_last);
  assign ring_ptr_o = ptr_q[OFS_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      fill_q <= '0;
      pcnt_q <= '0;
    end else if (clear_i) begin
      ptr_q  <= '0;
      fill_q <= '0;
      pcnt_q <= '0;
    end else begin
      if (store_pre) begin
        ptr_q <= (ptr_q + CNT_W'(1) == cfg_pre) ? '0 : ptr_q + CNT_W'(1);
        if (!pre_full) fill_q <= fill_q + CNT_W'(1);
      end
      if (store_post) pcnt_q <= pcnt_nxt;
    end
  end
endmodule

// File: rtl/rcc_seq.sv
// Record sequencing: phases, record index, slot and overflow tracking.
module rcc_seq
  import rcc_pkg::*;
#(
  parameter int NSLOT  = 4,
  parameter int RCNT_W = 31,
  localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              adv_edge_i,
  input  logic              ref_ok_i,
  input  logic              rec_end_i,
  input  logic [RCNT_W-1:0] cfg_records,
  input  logic [RCNT_W-1:0] fetched_cnt,
  output rcc_state_e        state_o,
  output logic              clear_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              ovf_o
);
  rcc_state_e        state_q, state_d;
  logic [RCNT_W-1:0] idx_q;
  logic [SLOT_W-1:0] slot_q;
  logic              ovf_q;
  logic [RCNT_W:0]   idx_nxt, ovf_lim;
  logic              begin_first, begin_next, last_rec;

  assign idx_nxt     = {1'b0, idx_q} + (RCNT_W+1)'(1);
  assign ovf_lim     = {1'b0, fetched_cnt} + (RCNT_W+1)'(NSLOT);
  assign last_rec    = (idx_nxt >= {1'b0, cfg_records});
  assign begin_first = start_i & ((state_q == ST_IDLE) | (state_q == ST_DONE));
  assign begin_next  = adv_edge_i & (state_q == ST_WAIT);
  assign clear_o     = begin_first | begin_next;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE, ST_DONE: if (begin_first) state_d = ST_PRE;
      ST_PRE: begin
        if (rec_end_i)     state_d = last_rec ? ST_DONE : ST_WAIT;
        else if (ref_ok_i) state_d = ST_POST;
      end
      ST_POST: if (rec_end_i) state_d = last_rec ? ST_DONE : ST_WAIT;
      ST_WAIT: if (begin_next) state_d = ST_PRE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      slot_q  <= '0;
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (begin_first) begin
        idx_q  <= '0;
        slot_q <= '0;
        ovf_q  <= 1'b0;
      end else if (begin_next) begin
        idx_q  <= idx_nxt[RCNT_W-1:0];
        slot_q <= (slot_q == SLOT_W'(NSLOT-1)) ? '0 : slot_q + SLOT_W'(1);
        if (idx_nxt >= ovf_lim) ovf_q <= 1'b1;
      end
    end
  end

  assign state_o = state_q;
  assign slot_o  = slot_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/rec_capture_ctrl.sv
module rec_capture_ctrl
  import rcc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OFS_W  = 3,
  parameter int NSLOT  = 4,
  parameter int RCNT_W = 31,
  localparam int CNT_W  = OFS_W + 1,
  localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int ADDR_W = SLOT_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              start_trig,
  input  logic              ref_trig,
  input  logic              adv_trig,
  input  logic              pause_trig,
  input  logic [CNT_W-1:0]  cfg_pre,
  input  logic [CNT_W-1:0]  cfg_post,
  input  logic [RCNT_W-1:0] cfg_records,
  input  logic              cfg_ref_fall,
  input  logic              cfg_adv_fall,
  input  logic [RCNT_W-1:0] fetched_cnt,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [OFS_W-1:0]  ref_pos,
  output logic              eor,
  output logic              rdy_adv,
  output logic              done,
  output logic              overflow
);
  localparam int NTRIG = 2;

  logic [NTRIG-1:0] trig_lvl, trig_fall, trig_edge;
  rcc_state_e       state;
  logic             clear, in_pre, in_post, take;
  logic             ref_ok, store, rec_end;
  logic [OFS_W-1:0] ofs, ring_ptr;
  logic [SLOT_W-1:0] slot;

  assign trig_lvl  = {adv_trig, ref_trig};
  assign trig_fall = {cfg_adv_fall, cfg_ref_fall};

  for (genvar g = 0; g < NTRIG; g++) begin : g_edge
    rcc_edge_det u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (trig_lvl[g]),
      .fall_i (trig_fall[g]),
      .edge_o (trig_edge[g])
    );
  end

  assign in_pre   = (state == ST_PRE);
  assign in_post  = (state == ST_POST);
  assign in_ready = in_pre | in_post;
  assign take     = in_valid & in_ready & ~pause_trig;

  rcc_seq #(.NSLOT(NSLOT), .RCNT_W(RCNT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_trig),
    .adv_edge_i  (trig_edge[1]),
    .ref_ok_i    (ref_ok),
    .rec_end_i   (rec_end),
    .cfg_records (cfg_records),
    .fetched_cnt (fetched_cnt),
    .state_o     (state),
    .clear_o     (clear),
    .slot_o      (slot),
    .ovf_o       (overflow)
  );

  rcc_window #(.OFS_W(OFS_W)) u_win (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (clear),
    .in_pre_i   (in_pre),
    .in_post_i  (in_post),
    .take_i     (take),
    .ref_edge_i (trig_edge[0]),
    .cfg_pre    (cfg_pre),
    .cfg_post   (cfg_post),
    .ref_ok_o   (ref_ok),
    .store_o    (store),
    .ofs_o      (ofs),
    .rec_end_o  (rec_end),
    .ring_ptr_o (ring_ptr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      ref_pos <= '0;
      eor     <= 1'b0;
    end else begin
      wr_en <= store;
      eor   <= rec_end;
      if (store) begin
        wr_addr <= {slot, ofs};
        wr_data <= in_data;
      end
      if (ref_ok) ref_pos <= ring_ptr;
    end
  end

  assign rdy_adv = (state == ST_WAIT);
  assign done    = (state == ST_DONE);
endmodule

// File: rtl/rec_capture_ctrl_chk.sv
module rec_capture_ctrl_chk #(
  parameter int OFS_W  = 3,
  parameter int ADDR_W = 5,
  localparam int CNT_W = OFS_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              pause_trig,
  input logic              start_trig,
  input logic [CNT_W-1:0]  cfg_pre,
  input logic [CNT_W-1:0]  cfg_post,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              eor,
  input logic              rdy_adv,
  input logic              done,
  input logic              overflow
);
  assert_offset_in_record_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ({2'b00, wr_addr[OFS_W-1:0]} < ({1'b0, cfg_pre} + {1'b0, cfg_post})));

  assert_eor_leaves_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eor |-> (rdy_adv || done));

  assert_wait_done_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rdy_adv && done));

  assert_pause_discards_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_trig && in_valid) |=> !wr_en);

  assert_no_write_unready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> !wr_en);

  assert_done_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start_trig) |=> done);

  assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !start_trig) |=> overflow);
endmodule

bind rec_capture_ctrl rec_capture_ctrl_chk #(.OFS_W(OFS_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .pause_trig (pause_trig),
  .start_trig (start_trig),
  .cfg_pre    (cfg_pre),
  .cfg_post   (cfg_post),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .eor        (eor),
  .rdy_adv    (rdy_adv),
  .done       (done),
  .overflow   (overflow)
);

// File: tb/rec_capture_ctrl_tb.sv
`timescale 1ns/1ps
module rec_capture_ctrl_tb;
  localparam int DATA_W = 8, OFS_W = 3, NSLOT = 4, CNT_W = 4, ADDR_W = 5;
  localparam int SLOTSZ = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_ready, start_trig = 0, ref_trig = 0, adv_trig = 0, pause_trig = 0;
  logic [DATA_W-1:0] in_data = '0;
  logic [CNT_W-1:0] cfg_pre = '0, cfg_post = '0;
  logic [30:0] cfg_records = 31'd1, fetched_cnt = '0;
  logic cfg_ref_fall = 0, cfg_adv_fall = 0;
  logic wr_en, eor, rdy_adv, done, overflow;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [OFS_W-1:0] ref_pos;

  always #2.5 clk = ~clk;

  rec_capture_ctrl #(.DATA_W(DATA_W), .OFS_W(OFS_W), .NSLOT(NSLOT)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .start_trig(start_trig), .ref_trig(ref_trig), .adv_trig(adv_trig), .pause_trig(pause_trig),
    .cfg_pre(cfg_pre), .cfg_post(cfg_post), .cfg_records(cfg_records),
    .cfg_ref_fall(cfg_ref_fall), .cfg_adv_fall(cfg_adv_fall), .fetched_cnt(fetched_cnt),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .ref_pos(ref_pos),
    .eor(eor), .rdy_adv(rdy_adv), .done(done), .overflow(overflow));

  int vectors = 0, fails = 0, cyc = 0;
  int wr_total = 0, eor_total = 0, cur_tag = 0;
  logic [7:0] mem_val [0:NSLOT*SLOTSZ-1];
  int         mem_tag [0:NSLOT*SLOTSZ-1];
  logic [7:0] seq = 8'h10;

  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      mem_val[wr_addr] <= wr_data;
      mem_tag[wr_addr] <= cur_tag;
      wr_total <= wr_total + 1;
    end
    if (rst_n && eor) eor_total <= eor_total + 1;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
        finish_run();
      end
    end
  end

  task automatic pulse_start();
    start_trig = 1; @(negedge clk); start_trig = 0;
  endtask

  task automatic pulse_adv();
    adv_trig = ~cfg_adv_fall; @(negedge clk); adv_trig = cfg_adv_fall;
  endtask

  // One record: pre phase with an early (ignored) reference edge, trigger, post phase.
  task automatic run_record(input int rec, input int pre, input int post, input bit usep);
    logic [7:0] acc [0:15];
    logic [7:0] pv  [0:15];
    int nacc = 0, npost = 0, base, wr0, eor0, rp, a;
    bit idle_r;
    idle_r = cfg_ref_fall;
    base = (rec % NSLOT) * SLOTSZ;
    @(negedge clk);
    cur_tag++;
    wr0 = wr_total; eor0 = eor_total;
    for (int k = 0; k < pre + 3; k++) begin
      in_valid = 1; in_data = seq;
      pause_trig = usep && (k % 3 == 1);
      ref_trig = (k == 0 && pre > 0) ? ~idle_r : idle_r; // R4: early edge ignored
      if (!pause_trig) begin acc[nacc] = seq; nacc++; end
      seq++;
      @(negedge clk);
    end
    ref_trig = ~idle_r; pause_trig = 0; in_data = seq;
    if (post > 0) begin pv[npost] = seq; npost++; end
    seq++;
    @(negedge clk);
    ref_trig = idle_r;
    for (int j = 0; j < post + 2; j++) begin
      pause_trig = usep && (j % 3 == 1); in_data = seq;
      if (!pause_trig && npost < post) begin pv[npost] = seq; npost++; end
      seq++;
      @(negedge clk);
    end
    in_valid = 0; pause_trig = 0;
    @(negedge clk); @(negedge clk);
    rp = (pre > 0) ? nacc % pre : 0;
    chk(ref_pos == rp[OFS_W-1:0], "R4/R13", "ref_pos", int'(ref_pos), rp);
    chk(eor_total - eor0 == 1, "R7", "eor pulses", eor_total - eor0, 1);
    chk(wr_total - wr0 == ((pre > 0) ? nacc : 0) + post, "R10", "write count",
        wr_total - wr0, ((pre > 0) ? nacc : 0) + post);
    for (int i = 0; i < pre; i++) begin
      a = base + (rp + i) % pre;
      chk(mem_tag[a] == cur_tag && mem_val[a] == acc[nacc - pre + i], "R3", "pre sample",
          int'(mem_val[a]), int'(acc[nacc - pre + i]));
    end
    for (int j = 0; j < post; j++) begin
      a = base + pre + j;
      chk(mem_tag[a] == cur_tag && mem_val[a] == pv[j], "R5", "post sample",
          int'(mem_val[a]), int'(pv[j]));
    end
  endtask

  initial begin
    for (int i = 0; i < NSLOT * SLOTSZ; i++) begin mem_val[i] = '0; mem_tag[i] = -1; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk({in_ready, wr_en, eor, rdy_adv, done, overflow} == 6'b0, "R1", "outputs after reset",
        int'({in_ready, wr_en, eor, rdy_adv, done, overflow}), 0);

    // R2, R12, R9: directed one-record run with cfg_records = 0
    cfg_pre = 4'd1; cfg_post = 4'd1; cfg_records = 31'd0;
    pulse_start();
    chk(in_ready == 1, "R2", "in_ready while filling", int'(in_ready), 1);
    in_valid = 1; in_data = 8'hA5;
    @(negedge clk);
    chk(wr_en == 1 && wr_addr == 0 && wr_data == 8'hA5, "R12", "write one cycle later",
        int'(wr_data), 8'hA5);
    ref_trig = 1; in_data = 8'h5A;
    @(negedge clk);
    ref_trig = 0; in_valid = 0;
    chk(wr_en == 1 && wr_addr == 1 && eor == 1, "R7", "last post write with eor",
        int'(wr_addr), 1);
    chk(done == 1 && in_ready == 0, "R9", "done after zero-count run", int'(done), 1);
    pulse_adv();
    @(negedge clk);
    chk(done == 1 && rdy_adv == 0, "R8", "advance ignored when done", int'(rdy_adv), 0);

    // Sweep of window sizes, two records each
    cfg_records = 31'd2;
    for (int p = 0; p <= 4; p++) begin
      for (int q = 0; q <= 4; q++) begin
        if (p + q == 0) continue;
        cfg_pre = CNT_W'(p); cfg_post = CNT_W'(q);
        pulse_start();
        run_record(0, p, q, bit'((p + q) % 2));
        chk(rdy_adv == 1 && done == 0 && in_ready == 0, "R8", "waiting for advance",
            int'(rdy_adv), 1);
        pulse_adv();
        run_record(1, p, q, bit'((p + q + 1) % 2));
        chk(done == 1 && rdy_adv == 0, "R9", "done after two records", int'(done), 1);
        chk(overflow == 0, "R11", "no overflow within slots", int'(overflow), 0);
      end
    end

    // R6 falling polarity
    cfg_ref_fall = 1; cfg_adv_fall = 1; ref_trig = 1; adv_trig = 1;
    @(negedge clk);
    cfg_pre = 4'd3; cfg_post = 4'd2;
    pulse_start();
    run_record(0, 3, 2, 1'b0);
    chk(rdy_adv == 1, "R6", "falling reference edge ends record", int'(rdy_adv), 1);
    pulse_adv();
    chk(in_ready == 1, "R6", "falling advance edge opens record", int'(in_ready), 1);
    run_record(1, 3, 2, 1'b1);
    cfg_ref_fall = 0; cfg_adv_fall = 0; ref_trig = 0; adv_trig = 0;
    @(negedge clk);

    // R11 overflow against fetched count
    cfg_pre = 4'd1; cfg_post = 4'd1; cfg_records = 31'd6;
    for (int f = 0; f < 2; f++) begin
      fetched_cnt = 31'(f);
      pulse_start();
      for (int r = 0; r < 6; r++) begin
        if (r > 0) pulse_adv();
        run_record(r, 1, 1, 1'b0);
        chk(overflow == (r >= f + NSLOT), "R11", "overflow flag", int'(overflow),
            int'(r >= f + NSLOT));
      end
    end

    finish_run();
  end
endmodule